// File: doc/BRIEF.md
# Serial Character Receiver with Two-Row Screen Buffer

This block takes an asynchronous serial line carrying 8N1 characters and stores each correctly framed byte in a small screen memory. The memory holds two rows of sixteen cells. A write cursor starts at the top-left cell. After every stored byte the cursor moves right. It continues onto the second row, and after the last cell it returns to the first cell.

A display engine elsewhere on the chip scans the memory without pause through its own read port. It presents a row and a column and gets the stored character in the same cycle. A mode input connects the receiver to the chip's own transmitter output in place of the external pin, which allows self-test without external wiring.

The receiver holds the line idle-high and synchronizes it through two flops. It treats a low level as a possible start bit and confirms it half a bit later. It then samples each following bit in the middle of its period, counting clocks with a parameterized bit timer. A frame whose stop bit reads low is rejected: a one-cycle error pulse is raised and the memory is left alone.

Top module: `uart_screen_rx`

## Requirements
- R1: After reset every one of the 32 cells reads 0x20 (space), the write cursor is at row 0 column 0, and `frame_err` is low.
- R2: A low level on the selected line that returns high before the half-bit check (CLKS_PER_BIT/2 clocks) is discarded. It writes no cell, does not move the cursor and raises no `frame_err`.
- R3: Each bit is sampled near the middle of its period. The first sample comes half a bit after the start edge and each later sample one bit period after the previous one, so disturbance in the first fifth of a bit period does not change the received value.
- R4: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The assembled byte is stored unchanged, for all 256 byte values.
- R5: If the stop bit samples low, `frame_err` is high for exactly one clock. No cell is written and the cursor stays where it was.
- R6: The cell index is row*16+column. After each stored byte the cursor moves from index n to n+1, from 15 to row 1 column 0, and from 31 back to 0.
- R7: `rd_char` shows the cell at (`rd_row`, `rd_col`) combinationally, in the same cycle the address is applied.
- R8: With `loop_en` at 1 the receiver listens only to `tx_serial` and ignores `rx_serial`. With `loop_en` at 0 it listens only to `rx_serial` and ignores `tx_serial`.
- R9: A frame ends with either a store or an error pulse, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_serial | input | 1 | Serial line from the external pin, idle high |
| tx_serial | input | 1 | Serial output of the on-chip transmitter, used in loopback |
| loop_en | input | 1 | 1 selects `tx_serial` as the receive source |
| rd_row | input | 1 | Display read row |
| rd_col | input | 4 | Display read column |
| rd_char | output | 8 | Character stored at the read address |
| frame_err | output | 1 | One-cycle pulse when a stop bit samples low |

## Verification
The bench sends every byte value, with every other frame carrying inverted noise at the front of each data bit. A receiver that samples at bit edges instead of mid-bit would store corrupted bytes. It sends more than 32 characters, so the jumps from cell 15 to row 1 and from cell 31 back to 0 are both crossed. A cursor with the wrong wrap would put characters in the wrong cells. A short low glitch and a frame with a low stop bit must both leave the memory and the cursor untouched. A design that wrote junk, or moved the cursor on an error, would shift every later character. Loopback is tested with the unused line held low, so a mux that picked the wrong source would receive false start bits or none at all.

// File: rtl/uart_scr_pkg.sv
package uart_scr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  localparam logic [7:0] BLANK_CHAR = 8'h20;

  // Cursor step with wrap, valid for any cell count
  function automatic int unsigned cursor_next(input int unsigned cur, input int unsigned cells);
    return (cur + 1 >= cells) ? 0 : cur + 1;
  endfunction

  // Linear cell index of a row/column pair
  function automatic int unsigned cell_index(input int unsigned row, input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_scr_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_s,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 byte_ok,
  output logic                 frame_err,
  output logic                 glitch_drop
);
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 2;
  localparam int IDX_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 2;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

  rx_state_t            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shift_q     <= '0;
      byte_ok     <= 1'b0;
      frame_err   <= 1'b0;
      glitch_drop <= 1'b0;
    end else begin
      byte_ok     <= 1'b0;
      frame_err   <= 1'b0;
      glitch_drop <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q <= '0;
            idx_q <= '0;
            if (rx_s) begin
              state_q     <= RX_IDLE;
              glitch_drop <= 1'b1;
            end else begin
              state_q <= RX_DATA;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == FULL_LAST) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
            if (idx_q == IDX_LAST) state_q <= RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == FULL_LAST) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (rx_s) byte_ok   <= 1'b1;
            else      frame_err <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign rx_byte = shift_q;
endmodule

// File: rtl/scr_buffer.sv
module scr_buffer
  import uart_scr_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 16,
  parameter int DW   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [DW-1:0]                         wr_data,
  input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] rd_row,
  input  logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] rd_col,
  output logic [DW-1:0]                         rd_data,
  output logic [$clog2(ROWS*COLS)-1:0]          cursor
);
  localparam int CELLS = ROWS * COLS;
  localparam int CUR_W = $clog2(CELLS);

  logic [DW-1:0]    mem_q [CELLS];
  logic [CUR_W-1:0] cur_q;
  int unsigned      rd_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      for (int i = 0; i < CELLS; i++) mem_q[i] <= DW'(BLANK_CHAR);
    end else if (wr_en) begin
      mem_q[cur_q] <= wr_data;
      cur_q        <= CUR_W'(cursor_next(int'(cur_q), CELLS));
    end
  end

  always_comb begin
    rd_idx  = cell_index(int'(rd_row), int'(rd_col), COLS);
    rd_data = DW'(BLANK_CHAR);
    if (rd_idx < CELLS) rd_data = mem_q[CUR_W'(rd_idx)];
  end

  assign cursor = cur_q;
endmodule

// File: rtl/uart_screen_rx.sv
module uart_screen_rx
  import uart_scr_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int ROWS         = 2,
  parameter int COLS         = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       rx_serial,
  input  logic                                       tx_serial,
  input  logic                                       loop_en,
  input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] rd_row,
  input  logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] rd_col,
  output logic [7:0]                                 rd_char,
  output logic                                       frame_err
);
  localparam int CUR_W = $clog2(ROWS * COLS);

  // Named internal events, observed by the bound checker
  logic             line_sel;
  logic             line_sync;
  logic [7:0]       rx_byte;
  logic             wr_pulse;
  logic             glitch_drop;
  logic [CUR_W-1:0] cursor_q;

  assign line_sel = loop_en ? tx_serial : rx_serial;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_sel),
    .dout (line_sync)
  );

  rx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_s       (line_sync),
    .rx_byte    (rx_byte),
    .byte_ok    (wr_pulse),
    .frame_err  (frame_err),
    .glitch_drop(glitch_drop)
  );

  scr_buffer #(.ROWS(ROWS), .COLS(COLS), .DW(8)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_pulse),
    .wr_data(rx_byte),
    .rd_row (rd_row),
    .rd_col (rd_col),
    .rd_data(rd_char),
    .cursor (cursor_q)
  );
endmodule

// File: rtl/uart_screen_rx_chk.sv
module uart_screen_rx_chk
  import uart_scr_pkg::*;
#(
  parameter int CUR_W = 5,
  parameter int CELLS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_pulse,
  input logic             frame_err,
  input logic             glitch_drop,
  input logic [CUR_W-1:0] cursor_q
);
  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pulse && frame_err));

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R6
  cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> cursor_q == CUR_W'(cursor_next(int'($past(cursor_q)), CELLS)));

  // R5
  cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(cursor_q));

  // R2
  glitch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_drop |=> !wr_pulse && !frame_err);
endmodule

bind uart_screen_rx uart_screen_rx_chk #(.CUR_W(CUR_W), .CELLS(ROWS * COLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_pulse   (wr_pulse),
  .frame_err  (frame_err),
  .glitch_drop(glitch_drop),
  .cursor_q   (cursor_q)
);

// File: tb/sim_uart_screen_rx.sv
module sim_uart_screen_rx;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tx_line = 1'b0;
  logic       loop_en = 1'b0;
  logic       rd_row = 1'b0;
  logic [3:0] rd_col = '0;
  logic [7:0] rd_char;
  logic       frame_err;

  int checks = 0;
  int fails = 0;
  int fe_cnt = 0;
  logic [7:0] exp_mem [32];
  int exp_cur = 0;

  always #5 clk = ~clk;

  uart_screen_rx #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_line), .tx_serial(tx_line),
    .loop_en(loop_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_char(rd_char), .frame_err(frame_err)
  );

  always @(posedge clk) if (rst_n && frame_err) fe_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_cell(input int idx, output logic [7:0] v);
    rd_row = 1'(idx / 16);
    rd_col = 4'(idx % 16);
    #1 v = rd_char;
  endtask

  task automatic check_cell(input string req, input int idx);
    logic [7:0] v;
    read_cell(idx, v);
    chk(req, int'(v), int'(exp_mem[idx]));
  endtask

  // R7: combinational read of every cell
  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) check_cell(req, i);
  endtask

  task automatic put_line(input logic v, input bit lb);
    if (lb) tx_line = v;
    else    rx_line = v;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v, input bit lb, input bit noisy);
    @(negedge clk);
    put_line(1'b0, lb);
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (noisy) begin
        put_line(~b[i], lb);
        repeat (3) @(negedge clk);
        put_line(b[i], lb);
        repeat (CPB - 3) @(negedge clk);
      end else begin
        put_line(b[i], lb);
        repeat (CPB) @(negedge clk);
      end
    end
    put_line(stop_v, lb);
    repeat (CPB) @(negedge clk);
    put_line(1'b1, lb);
    repeat (8) @(negedge clk);
  endtask

  task automatic model_store(input logic [7:0] b);
    exp_mem[exp_cur] = b;
    exp_cur = (exp_cur + 1) % 32;
  endtask

  task automatic send_good(input string req, input logic [7:0] b, input bit lb, input bit noisy);
    int pos;
    pos = exp_cur;
    send_frame(b, 1'b1, lb, noisy);
    model_store(b);
    check_cell(req, pos);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fe0;
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'h20;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk("R1 frame_err", int'(frame_err), 0);

    // R6 cursor order over 33 characters, crossing 15->16 and 31->0
    for (int i = 0; i < 33; i++) send_good("R6", 8'(8'h30 + i), 1'b0, 1'b0);
    check_all("R6");

    // R4 all byte values; R3 odd values carry edge noise
    for (int v = 0; v < 256; v++) send_good((v % 2 == 1) ? "R3" : "R4", 8'(v), 1'b0, v % 2 == 1);
    check_all("R4");

    // R5 bad stop bit
    fe0 = fe_cnt;
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R5 error pulses", fe_cnt - fe0, 1);
    check_all("R5");
    send_good("R5 cursor unmoved", 8'hA5, 1'b0, 1'b0);

    // R2 short glitch
    fe0 = fe_cnt;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    chk("R2 error pulses", fe_cnt - fe0, 0);
    check_all("R2");
    send_good("R2 cursor unmoved", 8'h7E, 1'b0, 1'b0);

    // R8 loopback: rx pin held low and ignored
    tx_line = 1'b1;
    loop_en = 1'b1;
    repeat (4) @(negedge clk);
    rx_line = 1'b0;
    send_good("R8 loop", 8'hC3, 1'b1, 1'b0);
    send_good("R8 loop", 8'h19, 1'b1, 1'b1);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    loop_en = 1'b0;
    tx_line = 1'b0;
    repeat (4) @(negedge clk);
    send_good("R8 pin", 8'h66, 1'b0, 1'b0);
    check_all("R8");
    chk("R9 no stray errors", fe_cnt - fe0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule